// File: doc/BRIEF.md
# Two-Line Level Interrupt Router

This block collects 32 level-sensitive interrupt sources into two processor interrupt lines: a normal line and a fast line. Each source is captured in a pending register on every clock, then passes through a per-source enable mask. A per-source steering mask sends it to either the fast line (steer bit 1) or the normal line (steer bit 0). Each line is the OR of its masked, steered pending bits.

Software sees the block through a simple register port. A request is a single cycle with `req_i` high. Writes take effect at the clock edge, and reads return data combinationally in the same cycle. Software can read the raw pending word and a masked pending word for each line, and it can program the enable and steering masks. An idle-mask control flag is stored and read back, but it never affects either output. Priority encoding and vectoring are left to the consumer of the two lines.

Top module: `intr_router`

## Requirements
- R1: On each rising clock edge, pending bit n takes the value of source n. The raw pending word reads at offset 0x0C, so a source change is visible there one cycle later.
- R2: `fast_irq_o` is high exactly when some bit is pending, enabled and steered fast (steer bit = 1).
- R3: `norm_irq_o` is high exactly when some bit is pending, enabled and steered normal (steer bit = 0).
- R4: A read at offset 0x00 returns pending AND enable AND NOT steer. A read at offset 0x10 returns pending AND enable AND steer.
- R5: The enable mask at offset 0x04 and the steering mask at offset 0x08 are full-width read/write registers.
- R6: The control register at offset 0x14 stores bit 0 as the idle-mask flag and reads it back in bit 0, with all other bits reading 0. Writing it leaves both outputs unchanged.
- R7: Reads at an unmapped offset return 0, and so do cycles with `req_i` low. Writes to an unmapped offset, or to the read-only offsets 0x00, 0x0C and 0x10, change no state.
- R8: After reset, every register reads 0 and both outputs are low.
- R9: A write to the enable or steering mask changes the outputs in the cycle that follows the write edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | NUM_SRC | Write data |
| rdata_o | output | NUM_SRC | Read data, valid in the request cycle |
| norm_irq_o | output | 1 | Normal interrupt line |
| fast_irq_o | output | 1 | Fast interrupt line |

## Verification
The assertions assume that sources are synchronous to `clk_i` and that a register access lasts a single cycle at a word-aligned offset. The idle-flag stability check also assumes that the sources do not change in the cycle of the control write. The bench changes sources and strobes only just after the falling edge and issues one access at a time. It holds the sources steady around control writes, so every property sees inputs that meet these assumptions.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;
  localparam int unsigned OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_NORM_PEND = 8'h00;
  localparam logic [OFF_W-1:0] OFF_ENABLE    = 8'h04;
  localparam logic [OFF_W-1:0] OFF_STEER     = 8'h08;
  localparam logic [OFF_W-1:0] OFF_RAW_PEND  = 8'h0C;
  localparam logic [OFF_W-1:0] OFF_FAST_PEND = 8'h10;
  localparam logic [OFF_W-1:0] OFF_CTRL      = 8'h14;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_NORM_PEND,
    SEL_ENABLE,
    SEL_STEER,
    SEL_RAW_PEND,
    SEL_FAST_PEND,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/intr_src_sampler.sv
module intr_src_sampler #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= src_i;
  end
endmodule

// File: rtl/intr_line_reduce.sv
module intr_line_reduce #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] steer_i,
  output logic [NUM_SRC-1:0] norm_word_o,
  output logic [NUM_SRC-1:0] fast_word_o,
  output logic               norm_irq_o,
  output logic               fast_irq_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic live;
    assign live           = pend_i[g] & enable_i[g];
    assign fast_word_o[g] = live & steer_i[g];
    assign norm_word_o[g] = live & ~steer_i[g];
  end

  assign norm_irq_o = |norm_word_o;
  assign fast_irq_o = |fast_word_o;
endmodule

// File: rtl/intr_regfile.sv
module intr_regfile
  import intr_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] norm_word_i,
  input  logic [NUM_SRC-1:0] fast_word_i,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [NUM_SRC-1:0] steer_o,
  output logic [NUM_SRC-1:0] rdata_o
);
  reg_sel_e sel;
  logic     idle_q;

  always_comb begin
    unique case (addr_i)
      ADDR_W'(OFF_NORM_PEND): sel = SEL_NORM_PEND;
      ADDR_W'(OFF_ENABLE):    sel = SEL_ENABLE;
      ADDR_W'(OFF_STEER):     sel = SEL_STEER;
      ADDR_W'(OFF_RAW_PEND):  sel = SEL_RAW_PEND;
      ADDR_W'(OFF_FAST_PEND): sel = SEL_FAST_PEND;
      ADDR_W'(OFF_CTRL):      sel = SEL_CTRL;
      default:                sel = SEL_NONE;
    endcase
  end

  logic wr;
  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      steer_o  <= '0;
      idle_q   <= 1'b0;
    end else if (wr) begin
      if (sel == SEL_ENABLE) enable_o <= wdata_i;
      if (sel == SEL_STEER)  steer_o  <= wdata_i;
      if (sel == SEL_CTRL)   idle_q   <= wdata_i[0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (sel)
        SEL_NORM_PEND: rdata_o = norm_word_i;
        SEL_ENABLE:    rdata_o = enable_o;
        SEL_STEER:     rdata_o = steer_o;
        SEL_RAW_PEND:  rdata_o = pend_i;
        SEL_FAST_PEND: rdata_o = fast_word_i;
        SEL_CTRL:      rdata_o = {{(NUM_SRC-1){1'b0}}, idle_q};
        default:       rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intr_router.sv
module intr_router #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic               norm_irq_o,
  output logic               fast_irq_o
);
  logic [NUM_SRC-1:0] pend_q, mask_q, sel_q, norm_word, fast_word;

  intr_src_sampler #(.NUM_SRC(NUM_SRC)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .pend_o (pend_q)
  );

  intr_line_reduce #(.NUM_SRC(NUM_SRC)) u_reduce (
    .pend_i      (pend_q),
    .enable_i    (mask_q),
    .steer_i     (sel_q),
    .norm_word_o (norm_word),
    .fast_word_o (fast_word),
    .norm_irq_o  (norm_irq_o),
    .fast_irq_o  (fast_irq_o)
  );

  intr_regfile #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .pend_i      (pend_q),
    .norm_word_i (norm_word),
    .fast_word_i (fast_word),
    .enable_o    (mask_q),
    .steer_o     (sel_q),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/intr_router_chk.sv
module intr_router_chk
  import intr_router_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic               req_i,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [NUM_SRC-1:0] wdata_i,
  input logic [NUM_SRC-1:0] rdata_o,
  input logic               norm_irq_o,
  input logic               fast_irq_o,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] sel_q
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  logic mapped;
  assign mapped = addr_i inside {ADDR_W'(OFF_NORM_PEND), ADDR_W'(OFF_ENABLE),
                                 ADDR_W'(OFF_STEER), ADDR_W'(OFF_RAW_PEND),
                                 ADDR_W'(OFF_FAST_PEND), ADDR_W'(OFF_CTRL)};

  assert_pend_follows_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> pend_q == $past(src_i));

  assert_fast_needs_steer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_irq_o |-> (pend_q & sel_q) != '0);

  assert_norm_needs_unsteer_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_irq_o |-> (pend_q & ~sel_q) != '0);

  assert_fast_word_steered_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_FAST_PEND)) |-> (rdata_o & ~sel_q) == '0);

  assert_mask_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_ENABLE)) |=> mask_q == $past(wdata_i));

  assert_ctrl_no_effect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_CTRL) && pend_q == src_i)
      |=> ($stable(fast_irq_o) && $stable(norm_irq_o)));

  assert_unmapped_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !mapped) |-> rdata_o == '0);
endmodule

bind intr_router intr_router_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/intr_router_test.sv
module intr_router_test;
  localparam int unsigned NUM_SRC = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NVEC = 6;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] mask;
    logic [31:0] steer;
    logic        exp_fast;
    logic        exp_norm;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0},
    '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 1'b0, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b0},
    '{32'h0000_00F0, 32'h0000_0030, 32'h0000_0010, 1'b1, 1'b1},
    '{32'h0000_0F00, 32'h0000_F000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{32'hA5A5_0000, 32'hFFFF_FFFF, 32'h5A5A_FFFF, 1'b0, 1'b1}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] src = '0;
  logic               req = 1'b0;
  logic               we = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [NUM_SRC-1:0] wdata = '0;
  logic [NUM_SRC-1:0] rdata;
  logic               norm_irq, fast_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_router #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .norm_irq_o (norm_irq),
    .fast_irq_o (fast_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R8 reset state
    check("R8 fast", {31'b0, fast_irq}, 32'd0);
    check("R8 norm", {31'b0, norm_irq}, 32'd0);
    rd(8'h04, d); check("R8 mask", d, 32'd0);
    rd(8'h08, d); check("R8 steer", d, 32'd0);
    rd(8'h14, d); check("R8 ctrl", d, 32'd0);
    rd(8'h0C, d); check("R8 raw", d, 32'd0);

    // table walk: R2 R3 R4 R5 R1
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h04, VECS[i].mask);
      wr(8'h08, VECS[i].steer);
      src = VECS[i].src;
      tick();
      check("R2 fast line", {31'b0, fast_irq}, {31'b0, VECS[i].exp_fast});
      check("R3 norm line", {31'b0, norm_irq}, {31'b0, VECS[i].exp_norm});
      rd(8'h00, d); check("R4 norm word", d, VECS[i].src & VECS[i].mask & ~VECS[i].steer);
      rd(8'h10, d); check("R4 fast word", d, VECS[i].src & VECS[i].mask & VECS[i].steer);
      rd(8'h0C, d); check("R1 raw pend", d, VECS[i].src);
      rd(8'h04, d); check("R5 mask rb", d, VECS[i].mask);
      rd(8'h08, d); check("R5 steer rb", d, VECS[i].steer);
    end

    // R1 one-cycle latency
    src = 32'h0000_0000; tick();
    src = 32'h0001_0000;
    rd(8'h0C, d); check("R1 before edge", d, 32'h0000_0000);
    tick();
    rd(8'h0C, d); check("R1 after edge", d, 32'h0001_0000);

    // R9 mask/steer take effect next cycle
    wr(8'h04, 32'h0000_0000);
    wr(8'h08, 32'h0000_0000);
    check("R9 norm off", {31'b0, norm_irq}, 32'd0);
    wr(8'h04, 32'h0001_0000);
    check("R9 norm on", {31'b0, norm_irq}, 32'd1);
    wr(8'h08, 32'h0001_0000);
    check("R9 steer to fast", {31'b0, fast_irq}, 32'd1);
    check("R9 norm dropped", {31'b0, norm_irq}, 32'd0);

    // R6 control flag
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R6 ctrl rb", d, 32'h0000_0001);
    check("R6 fast unchanged", {31'b0, fast_irq}, 32'd1);
    check("R6 norm unchanged", {31'b0, norm_irq}, 32'd0);
    wr(8'h14, 32'h0000_0002);
    rd(8'h14, d); check("R6 ctrl clear", d, 32'h0000_0000);
    check("R6 fast still", {31'b0, fast_irq}, 32'd1);

    // R7 unmapped and read-only
    rd(8'h18, d); check("R7 unmapped rd", d, 32'd0);
    rd(8'h02, d); check("R7 misaligned rd", d, 32'd0);
    req = 1'b0; we = 1'b0; addr = 8'h04; #1;
    check("R7 idle rdata", rdata, 32'd0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R7 raw ro", d, 32'h0001_0000);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h04, d); check("R7 mask kept", d, 32'h0001_0000);
    rd(8'h08, d); check("R7 steer kept", d, 32'h0001_0000);
    rd(8'h14, d); check("R7 ctrl kept", d, 32'h0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule